// File: doc/BRIEF.md
# Dual Interval Timer with Register Access

This block is a small timer peripheral for a processor subsystem. It holds one or two independent counters, each as wide as the data bus. Software reaches each counter through a window of four word registers: a control and status word, a load value, a read-only live count, and one unused word.

Writing the control word with the enable bit set starts the counter from its load value. The counter then steps by one on every clock, upward or downward as the control word selects. At its terminal value it raises an expired flag, and it either reloads and continues or stops. The flags, gated by per-counter interrupt enables, are ORed onto one interrupt pin.

The bus side is a plain single-cycle word interface. A write takes effect on the clock edge where `wr_en` is high. Read data follows the address combinationally, so there is no handshake and no back-pressure. A parameter removes the second counter, and its register window then reads as zero.

Top module: `ivt_top`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and `irq` is low.
- R2: Word address bits [ADDR_W-1:2] pick the counter and bits [1:0] pick the register: 0 is control, 1 is load, 2 is count and 3 is unused. The control bits are: 1 down-count, 4 auto-reload, 6 interrupt enable, 7 enable and 8 expired. Bits 0, 2, 3, 5, 9 and 10 are stored and read back with no other effect. Bits 31:11 read as zero.
- R3: A control write with bit 7 set makes the count equal the load value on the next cycle. After that the count moves by one per cycle: it decrements when bit 1 is set and increments when it is clear.
- R4: A counter counting down that holds zero sets its expired flag on the next edge. With auto-reload it restarts from the load value on that edge; without auto-reload it stops and holds zero.
- R5: A counter counting up that holds all ones sets its expired flag on the next edge. With auto-reload it restarts from the load value on that edge; without auto-reload it stops and holds all ones.
- R6: Write data never sets the expired flag, and any control write clears it. The flag stays set until such a write. If a write and an expiry fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly when some present counter has both its expired flag and its interrupt enable set.
- R8: A control write with bit 7 clear stops the counter, and it keeps its current count.
- R9: Reads of word 3 and of addresses past the window return zero, and writes to them change nothing. Writes to the count register change nothing.
- R10: With `TWO_CNT` = 0 only words 0 to 3 exist. Words 4 to 7 then read zero, and writes to them cannot raise `irq`.
- R11: A load write does not disturb a running count. The new value is used at the next start or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Shared interrupt |

## Verification
Load values from 0 to 5 are swept in the down direction, and the same distances from all ones in the up direction, on both counters, with the count read on every cycle. Any off-by-one in the start edge or in the terminal edge shows up in these sweeps. Auto-reload runs over several periods separate a correct reload from a stop or a wrap. Masked and unmasked flags on the two counters separate the OR from a per-counter output. A control write placed on the expiry edge shows which of the two wins. Writes to holes, to the count register and to the missing second counter show whether the decode leaks into real state.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CSR_W  = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_AUTO = 4;
  localparam int B_LDB  = 5;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NCNT   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [NCNT-1:0]   slot_hit,
  output reg_sel_e          sel,
  output logic [NCNT-1:0]   wr_ctrl,
  output logic [NCNT-1:0]   wr_load
);
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;

  assign slot = addr[ADDR_W-1:2];
  assign sel  = reg_sel_e'(addr[1:0]);

  for (genvar g = 0; g < NCNT; g++) begin : g_slot
    assign slot_hit[g] = (slot == SLOT_W'(g));
    assign wr_ctrl[g]  = wr_en && slot_hit[g] && (sel == SEL_CTRL);
    assign wr_load[g]  = wr_en && slot_hit[g] && (sel == SEL_LOAD);
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wdata,
  output logic [CSR_W-1:0]  csr,
  output logic [DATA_W-1:0] load,
  output logic [DATA_W-1:0] count,
  output logic              run
);
  logic [CSR_W-1:0]  csr_q, csr_wr;
  logic [DATA_W-1:0] load_q, count_q, term;
  logic              run_q, down, expire;

  assign down   = csr_q[B_DOWN];
  assign term   = down ? '0 : '1;
  assign expire = run_q && (count_q == term);

  // control word as written: the flag only comes from an expiry on this edge
  always_comb begin
    csr_wr         = wdata[CSR_W-1:0];
    csr_wr[B_FLAG] = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
    end else if (wr_ctrl) begin
      csr_q <= csr_wr;
    end else if (expire) begin
      csr_q[B_FLAG] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_load) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (wr_ctrl) begin
      if (wdata[B_EN]) begin
        count_q <= load_q;
        run_q   <= 1'b1;
      end else begin
        run_q   <= 1'b0;
      end
    end else if (expire) begin
      if (csr_q[B_AUTO]) begin
        count_q <= load_q;
      end else begin
        run_q   <= 1'b0;
      end
    end else if (run_q) begin
      count_q <= down ? count_q - DATA_W'(1) : count_q + DATA_W'(1);
    end
  end

  assign csr   = csr_q;
  assign load  = load_q;
  assign count = count_q;
  assign run   = run_q;
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
  import ivt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCNT   = 2
) (
  input  logic [NCNT-1:0]              slot_hit,
  input  reg_sel_e                     sel,
  input  logic [NCNT-1:0][CSR_W-1:0]   csr_v,
  input  logic [NCNT-1:0][DATA_W-1:0]  load_v,
  input  logic [NCNT-1:0][DATA_W-1:0]  cnt_v,
  output logic [DATA_W-1:0]            rdata
);
  always_comb begin
    rdata = '0;
    for (int g = 0; g < NCNT; g++) begin
      if (slot_hit[g]) begin
        unique case (sel)
          SEL_CTRL:  rdata = DATA_W'(csr_v[g]);
          SEL_LOAD:  rdata = load_v[g];
          SEL_COUNT: rdata = cnt_v[g];
          SEL_NONE:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int TWO_CNT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NCNT = (TWO_CNT != 0) ? 2 : 1;

  logic [NCNT-1:0]             slot_hit, wr_ctrl_v, wr_load_v;
  reg_sel_e                    sel;
  logic [NCNT-1:0][CSR_W-1:0]  csr_v;
  logic [NCNT-1:0][DATA_W-1:0] load_v, cnt_v;
  logic [NCNT-1:0]             run_v, down_v, auto_v, ie_v, flag_v;

  ivt_decode #(.ADDR_W(ADDR_W), .NCNT(NCNT)) u_dec (
    .addr(addr), .wr_en(wr_en), .slot_hit(slot_hit), .sel(sel),
    .wr_ctrl(wr_ctrl_v), .wr_load(wr_load_v)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    ivt_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_ctrl_v[g]), .wr_load(wr_load_v[g]), .wdata(wdata),
      .csr(csr_v[g]), .load(load_v[g]), .count(cnt_v[g]), .run(run_v[g])
    );
    assign down_v[g] = csr_v[g][B_DOWN];
    assign auto_v[g] = csr_v[g][B_AUTO];
    assign ie_v[g]   = csr_v[g][B_IE];
    assign flag_v[g] = csr_v[g][B_FLAG];
  end

  ivt_rdmux #(.DATA_W(DATA_W), .NCNT(NCNT)) u_rd (
    .slot_hit(slot_hit), .sel(sel), .csr_v(csr_v), .load_v(load_v),
    .cnt_v(cnt_v), .rdata(rdata)
  );

  assign irq = |(flag_v & ie_v);
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int TWO_CNT = 1
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [ADDR_W-1:0]                      addr,
  input logic [DATA_W-1:0]                      rdata,
  input logic                                   irq,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    wr_ctrl_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    run_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    down_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    auto_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    ie_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0]    flag_v,
  input logic [((TWO_CNT != 0) ? 2 : 1)-1:0][DATA_W-1:0] cnt_v
);
  localparam int NCNT   = (TWO_CNT != 0) ? 2 : 1;
  localparam int SLOT_W = ADDR_W - 2;

  // R9: holes and out-of-window addresses read zero
  a_r9_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr[1:0] == 2'd3) || (addr[ADDR_W-1:2] >= SLOT_W'(NCNT))) |-> (rdata == '0));

  // R7: no enable or no flag means no interrupt
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((ie_v == '0) || (flag_v == '0)) |-> !irq);

  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    // R3: down counting steps by one
    a_r3_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && down_v[g] && (cnt_v[g] != '0) && !wr_ctrl_v[g])
        |=> (cnt_v[g] == $past(cnt_v[g]) - DATA_W'(1)));
    // R3: up counting steps by one
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && !down_v[g] && (cnt_v[g] != '1) && !wr_ctrl_v[g])
        |=> (cnt_v[g] == $past(cnt_v[g]) + DATA_W'(1)));
    // R4: down expiry without reload stops at zero with flag
    a_r4_down_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && down_v[g] && (cnt_v[g] == '0) && !auto_v[g] && !wr_ctrl_v[g])
        |=> (!run_v[g] && flag_v[g] && (cnt_v[g] == '0)));
    // R5: up expiry without reload stops at all ones with flag
    a_r5_up_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && !down_v[g] && (cnt_v[g] == '1) && !auto_v[g] && !wr_ctrl_v[g])
        |=> (!run_v[g] && flag_v[g] && (cnt_v[g] == '1)));
    // R6: flag is sticky until a control write
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[g] && !wr_ctrl_v[g]) |=> flag_v[g]);
  end
endmodule

bind ivt_top ivt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TWO_CNT(TWO_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .irq(irq),
  .wr_ctrl_v(wr_ctrl_v), .run_v(run_v), .down_v(down_v), .auto_v(auto_v),
  .ie_v(ie_v), .flag_v(flag_v), .cnt_v(cnt_v)
);

// File: tb/tb_ivt_top.sv
`timescale 1ns/1ps
module tb_ivt_top;
  localparam logic [31:0] C_DOWN = 32'h2, C_AUTO = 32'h10, C_IE = 32'h40,
                          C_EN = 32'h80, C_FLAG = 32'h100;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, done = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rdata1;
  logic        irq, irq1;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ivt_top #(.DATA_W(32), .ADDR_W(4), .TWO_CNT(1)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq));
  ivt_top #(.DATA_W(32), .ADDR_W(4), .TWO_CNT(0)) dut_one (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata1), .irq(irq1));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2 stored bits, upper bits dropped; R6 flag not from data
    wr(0, 32'hFFFF_FF2D); rd(0, v);
    chk("R2 ctrl readback", v, 32'h0000_062D);
    chk("R6 flag not written", v & C_FLAG, 32'h0);
    wr(0, 0);

    // R3/R4 down sweep on both counters
    for (int c = 0; c < 2; c++) begin
      for (int l = 0; l < 6; l++) begin
        wr(4'(c*4+1), l);
        wr(4'(c*4), C_EN | C_DOWN | C_IE);
        for (int i = 0; i <= l; i++) begin
          rd(4'(c*4+2), v); chk("R3 down count", v, 32'(l - i));
          chk("R7 irq low while counting", {31'b0, irq}, 32'h0);
          step(1);
        end
        rd(4'(c*4), v); chk("R4 down flag", v & C_FLAG, C_FLAG);
        chk("R7 irq on expiry", {31'b0, irq}, 32'h1);
        step(1); rd(4'(c*4+2), v); chk("R4 down stop holds zero", v, 32'h0);
        wr(4'(c*4), 0); rd(4'(c*4), v);
        chk("R6 write clears flag", v & C_FLAG, 32'h0);
        chk("R7 irq after clear", {31'b0, irq}, 32'h0);
      end
    end

    // R5 up sweep on both counters
    for (int c = 0; c < 2; c++) begin
      for (int l = 0; l < 6; l++) begin
        wr(4'(c*4+1), 32'hFFFF_FFFF - 32'(l));
        wr(4'(c*4), C_EN | C_IE);
        for (int i = 0; i <= l; i++) begin
          rd(4'(c*4+2), v); chk("R3 up count", v, 32'hFFFF_FFFF - 32'(l - i));
          step(1);
        end
        rd(4'(c*4), v); chk("R5 up flag", v & C_FLAG, C_FLAG);
        step(1); rd(4'(c*4+2), v); chk("R5 up stop holds ones", v, 32'hFFFF_FFFF);
        wr(4'(c*4), 0);
      end
    end

    // R4 auto-reload down, several periods
    wr(1, 3); wr(0, C_EN | C_DOWN | C_AUTO);
    for (int p = 0; p < 3; p++) begin
      step(4); rd(2, v); chk("R4 auto reload count", v, 32'd3);
      rd(0, v); chk("R4 auto flag", v & C_FLAG, C_FLAG);
    end
    wr(0, 0);
    // R5 auto-reload up
    wr(1, 32'hFFFF_FFFE); wr(0, C_EN | C_AUTO);
    for (int p = 0; p < 3; p++) begin
      step(2); rd(2, v); chk("R5 auto reload count", v, 32'hFFFF_FFFE);
    end
    wr(0, 0);

    // R7 masking and sharing
    wr(1, 1); wr(0, C_EN | C_DOWN); step(3);
    rd(0, v); chk("R7 masked flag set", v & C_FLAG, C_FLAG);
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    wr(5, 0); wr(4, C_EN | C_DOWN | C_IE); step(1);
    chk("R7 irq from counter 1", {31'b0, irq}, 32'h1);
    wr(4, 0);
    chk("R7 irq drops with other flag masked", {31'b0, irq}, 32'h0);
    wr(0, 0);

    // R6 expiry coinciding with a control write
    wr(1, 0); wr(0, C_EN | C_DOWN); wr(0, C_EN | C_DOWN);
    rd(0, v); chk("R6 expiry wins over write", v & C_FLAG, C_FLAG);
    wr(0, 0);

    // R8 stop keeps count
    wr(1, 10); wr(0, C_EN | C_DOWN); step(3);
    wr(0, C_DOWN); rd(2, v); chk("R8 stop holds count", v, 32'd7);
    step(5); rd(2, v); chk("R8 stays stopped", v, 32'd7);

    // R11 load write while running
    wr(1, 5); wr(0, C_EN | C_DOWN | C_AUTO); step(2);
    wr(1, 2); rd(2, v); chk("R11 count undisturbed", v, 32'd2);
    step(2); rd(2, v); chk("R11 reaches zero", v, 32'd0);
    step(1); rd(2, v); chk("R11 reload uses new load", v, 32'd2);
    wr(0, 0); rd(2, keep);

    // R9 holes and count writes
    wr(3, 32'h1234_5678); rd(3, v); chk("R9 word3 reads zero", v, 32'h0);
    wr(8, C_EN | C_IE); wr(12, 32'hFFFF_FFFF);
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), v); chk("R9 out of window zero", v, 32'h0);
    end
    rd(0, v); chk("R9 ctrl untouched", v, 32'h0);
    wr(2, 32'h55); rd(2, v); chk("R9 count write ignored", v, keep);
    step(3); chk("R9 no irq", {31'b0, irq}, 32'h0);

    // R10 single-counter configuration
    addr = 4; #1; chk("R10 word4 zero", rdata1, 32'h0);
    addr = 5; #1; chk("R10 word5 zero", rdata1, 32'h0);
    addr = 6; #1; chk("R10 word6 zero", rdata1, 32'h0);
    wr(5, 0); wr(4, C_EN | C_DOWN | C_IE); step(2);
    chk("R10 two-counter irq", {31'b0, irq}, 32'h1);
    chk("R10 one-counter no irq", {31'b0, irq1}, 32'h0);
    addr = 4; #1; chk("R10 ctrl absent", rdata1, 32'h0);
    wr(4, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule